// File: doc/BRIEF.md
# Tagged Receive Demultiplexing Queues

This unit sits between a tile's network input port and its processor. Words arrive as messages on a single valid/ready stream. Each message starts with a header word whose low bits give the payload length. A tag word follows the header. The tag word encodes the sending node, the stream number and the message type. The payload words come after the tag. The unit compares the tag with a set of programmable tag values, one for each demultiplexing queue, and writes the payload into the queue that matches. The tag word itself is consumed and is not stored.

A message whose tag matches none of the programmed values goes to an extra catch-all queue. An interrupt line stays high for as long as that queue holds any word. The processor drains each queue through its own register-style read port, which uses valid/ready. Each queue also shows its empty flag and its word count.

Back-pressure works as follows. The header word and the tag word are always accepted. A payload word is accepted only while its destination queue has room. When that queue is full, `in_ready` drops and the word is held on the link until the processor pops an entry. No word is ever dropped. On the read side, a pop happens on a clock edge where both `q_valid[i]` and `q_ready[i]` are high.

Top module: `rxdmx_top`

## Requirements
- R1: After reset, every queue is empty with a count of zero, `q_valid` is all zero, `catch_irq` is low and `in_ready` is high.
- R2: A message is a header word, then a tag word, then the payload. Header bits [LENW-1:0] give the number of payload words. The header and the tag word are never written into any queue.
- R3: The payload words are written, in arrival order, into the demultiplexing queue i whose tag `cfg_tags[i*W +: W]` equals the message tag.
- R4: When several queue tags are equal to the message tag, the lowest-numbered of those queues receives the payload, and the other queues stay unchanged.
- R5: When no queue tag matches, the payload goes to the catch-all queue, which is read port index NQ.
- R6: `catch_irq` is high exactly while the catch-all queue is non-empty.
- R7: While the destination queue of a payload word is full, `in_ready` is low and the word is not lost. It is accepted after a pop frees space, and order is preserved.
- R8: A word accepted at a clock edge shows up in `q_count`, `q_empty` and `q_valid` after that edge. A pop at an edge lowers the count after that edge.
- R9: A header with length zero followed by its tag word stores nothing, and the next word is taken as a new header.
- R10: `q_data[i]` shows the oldest word of queue i whenever `q_valid[i]` is high. Raising `q_ready[i]` on an empty queue has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming network word valid |
| in_ready | output | 1 | Unit can take the incoming word |
| in_data | input | W | Incoming network word |
| cfg_tags | input | NQ*W | Programmed tag of each demultiplexing queue, queue i at bits [i*W +: W] |
| q_valid | output | NQ+1 | Queue holds a word; index NQ is the catch-all queue |
| q_ready | input | NQ+1 | Pop request from the processor, one bit per queue |
| q_data | output | (NQ+1)*W | Head word of each queue |
| q_empty | output | NQ+1 | Queue empty flags |
| q_count | output | (NQ+1)*CW | Word count of each queue, CW = clog2(QDEPTH+1) |
| catch_irq | output | 1 | Interrupt, high while the catch-all queue is non-empty |

## Verification
A payload word accepted at a rising edge is visible on the count, empty, valid and interrupt outputs right after that edge. A pop takes effect on the same schedule. `in_ready` is combinational on the head-of-queue fill state, so it changes within the same cycle as a pop edge. The bench changes inputs just after a rising edge and reads every output at the following falling edge, so each result is sampled one half cycle after the edge that produces it. The sweep runs through every tag class and every payload length up to the queue depth. A separate test holds a word against a full queue for several cycles before draining it.

// File: rtl/rxdmx_pkg.sv
package rxdmx_pkg;
  typedef enum logic [1:0] {
    PH_HDR = 2'd0,
    PH_TAG = 2'd1,
    PH_PAY = 2'd2
  } phase_e;
endpackage

// File: rtl/rxdmx_tagmatch.sv
module rxdmx_tagmatch #(
  parameter int W  = 32,
  parameter int NQ = 4,
  localparam int IW = (NQ + 1 > 1) ? $clog2(NQ + 1) : 1
) (
  input  logic [W-1:0]    tag,
  input  logic [NQ*W-1:0] cfg_tags,
  output logic            hit,
  output logic [IW-1:0]   sel
);
  // scan high to low so the lowest matching index is written last
  always_comb begin
    hit = 1'b0;
    sel = IW'(NQ);
    for (int i = NQ - 1; i >= 0; i--) begin
      if (cfg_tags[i*W +: W] == tag) begin
        hit = 1'b1;
        sel = IW'(i);
      end
    end
  end
endmodule

// File: rtl/rxdmx_queue.sv
module rxdmx_queue #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop_req,
  output logic [W-1:0]  head,
  output logic          valid,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign valid   = !empty;
  assign head    = mem[rd_ptr];
  assign push_ok = push && !full;
  assign pop_ok  = pop_req && !empty;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      count <= count + CW'(push_ok) - CW'(pop_ok);
    end
  end

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  p_pop_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && empty && !push) |=> empty);
  p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
endmodule

// File: rtl/rxdmx_steer.sv
module rxdmx_steer
  import rxdmx_pkg::*;
#(
  parameter int W    = 32,
  parameter int NQ   = 4,
  parameter int LENW = 8,
  localparam int IW = (NQ + 1 > 1) ? $clog2(NQ + 1) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [W-1:0]    in_data,
  input  logic [NQ*W-1:0] cfg_tags,
  input  logic [NQ:0]     dest_full,
  output logic [NQ:0]     push
);
  phase_e          phase;
  logic [LENW-1:0] remain;
  logic [IW-1:0]   dest;
  logic            hit;
  logic [IW-1:0]   sel;
  logic            acc;

  rxdmx_tagmatch #(.W(W), .NQ(NQ)) u_match (
    .tag      (in_data),
    .cfg_tags (cfg_tags),
    .hit      (hit),
    .sel      (sel)
  );

  assign in_ready = (phase != PH_PAY) || !dest_full[dest];
  assign acc      = in_valid && in_ready;

  always_comb begin
    for (int i = 0; i <= NQ; i++) begin
      push[i] = acc && (phase == PH_PAY) && (dest == IW'(i));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= PH_HDR;
      remain <= '0;
      dest   <= '0;
    end else if (acc) begin
      unique case (phase)
        PH_HDR: begin
          remain <= in_data[LENW-1:0];
          phase  <= PH_TAG;
        end
        PH_TAG: begin
          dest  <= hit ? sel : IW'(NQ);
          phase <= (remain == '0) ? PH_HDR : PH_PAY;
        end
        default: begin
          remain <= remain - LENW'(1);
          if (remain == LENW'(1)) phase <= PH_HDR;
        end
      endcase
    end
  end

  p_tag_not_stored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_PAY) |-> (push == '0));
  p_single_dest_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(push));
  p_stall_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |-> (phase == PH_PAY && dest_full[dest]));
endmodule

// File: rtl/rxdmx_top.sv
module rxdmx_top #(
  parameter int W      = 32,
  parameter int NQ     = 4,
  parameter int QDEPTH = 16,
  parameter int LENW   = 8
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 in_valid,
  output logic                                 in_ready,
  input  logic [W-1:0]                         in_data,
  input  logic [NQ*W-1:0]                      cfg_tags,
  output logic [NQ:0]                          q_valid,
  input  logic [NQ:0]                          q_ready,
  output logic [(NQ+1)*W-1:0]                  q_data,
  output logic [NQ:0]                          q_empty,
  output logic [(NQ+1)*$clog2(QDEPTH+1)-1:0]   q_count,
  output logic                                 catch_irq
);
  localparam int CW = $clog2(QDEPTH + 1);

  logic [NQ:0] q_push;
  logic [NQ:0] q_full;

  rxdmx_steer #(.W(W), .NQ(NQ), .LENW(LENW)) u_steer (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .cfg_tags  (cfg_tags),
    .dest_full (q_full),
    .push      (q_push)
  );

  for (genvar g = 0; g <= NQ; g++) begin : g_q
    rxdmx_queue #(.W(W), .DEPTH(QDEPTH)) u_q (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (q_push[g]),
      .push_data (in_data),
      .pop_req   (q_ready[g]),
      .head      (q_data[g*W +: W]),
      .valid     (q_valid[g]),
      .full      (q_full[g]),
      .empty     (q_empty[g]),
      .count     (q_count[g*CW +: CW])
    );
  end

  assign catch_irq = q_valid[NQ];

  p_irq_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(catch_irq) |-> $past(q_push[NQ]));
  p_irq_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(catch_irq) |-> $past(q_ready[NQ]));
endmodule

// File: tb/rxdmx_top_test.sv
module rxdmx_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 32;
  localparam int NQ = 4;
  localparam int QD = 4;
  localparam int CW = $clog2(QD + 1);

  localparam logic [W-1:0] TG0  = 32'h0001_0A01;
  localparam logic [W-1:0] TG1  = 32'h0002_0B02;
  localparam logic [W-1:0] TG3  = 32'h0003_0C03;
  localparam logic [W-1:0] MISS = 32'h00FF_EEEE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [W-1:0] in_data = '0;
  logic [NQ*W-1:0] cfg_tags;
  logic [NQ:0] q_valid;
  logic [NQ:0] q_ready = '0;
  logic [(NQ+1)*W-1:0] q_data;
  logic [NQ:0] q_empty;
  logic [(NQ+1)*CW-1:0] q_count;
  logic catch_irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // queue 2 deliberately shares the tag of queue 1
  assign cfg_tags = {TG3, TG1, TG1, TG0};

  always #(CLK_PERIOD/2) clk = ~clk;

  rxdmx_top #(.W(W), .NQ(NQ), .QDEPTH(QD), .LENW(8)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .cfg_tags(cfg_tags), .q_valid(q_valid),
    .q_ready(q_ready), .q_data(q_data), .q_empty(q_empty),
    .q_count(q_count), .catch_irq(catch_irq)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int cnt(input int q);
    return int'(q_count[q*CW +: CW]);
  endfunction

  function automatic logic [W-1:0] word_of(input int ti, input int len, input int k);
    return {8'(ti), 8'(len), 16'(k) + 16'h0100};
  endfunction

  task automatic send_word(input logic [W-1:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = w;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic pop_check(input int q, input logic [W-1:0] exp, input string req);
    @(negedge clk);
    while (!q_valid[q]) @(negedge clk);
    chk(q_data[q*W +: W] == exp, req, q_data[q*W +: W], exp);
    q_ready[q] = 1'b1;
    @(posedge clk);
    #1 q_ready[q] = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    logic [W-1:0] tags [5];
    int dq [5];
    tags[0] = TG0; tags[1] = TG1; tags[2] = TG1; tags[3] = TG3; tags[4] = MISS;
    dq[0] = 0; dq[1] = 1; dq[2] = 1; dq[3] = 3; dq[4] = 4;

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    chk(q_valid == '0, "R1 q_valid", q_valid, 0);
    chk(q_empty == '1, "R1 q_empty", q_empty, 5'h1f);
    chk(q_count == '0, "R1 q_count", q_count, 0);
    chk(catch_irq == 1'b0, "R1 catch_irq", catch_irq, 0);

    // R10 pop on empty queues has no effect
    q_ready = '1;
    @(posedge clk);
    #1 q_ready = '0;
    @(negedge clk);
    chk(q_count == '0, "R10 pop on empty", q_count, 0);

    // sweep every tag class and every length up to the depth
    for (int ti = 0; ti < 5; ti++) begin
      for (int len = 0; len <= QD; len++) begin
        send_word(W'(len) | 32'hAB00_0000);
        send_word(tags[ti]);
        for (int k = 0; k < len; k++) send_word(word_of(ti, len, k));
        @(negedge clk);
        for (int q = 0; q <= NQ; q++) begin
          int e;
          e = (q == dq[ti]) ? len : 0;
          // R2 tag not stored, R3 steering, R4 lowest wins, R5 catch-all, R9 zero length
          chk(cnt(q) == e, (ti == 2) ? "R4 count" : (ti == 4) ? "R5 count" :
              (len == 0) ? "R9 count" : "R3 R2 count", cnt(q), e);
          chk(q_empty[q] == (e == 0), "R8 empty flag", q_empty[q], e == 0);
        end
        chk(catch_irq == (dq[ti] == 4 && len > 0), "R6 irq while held", catch_irq,
            dq[ti] == 4 && len > 0);
        for (int k = 0; k < len; k++)
          pop_check(dq[ti], word_of(ti, len, k), "R10 R3 order");
        @(negedge clk);
        chk(q_count == '0, "R8 drained", q_count, 0);
        chk(catch_irq == 1'b0, "R6 irq clear", catch_irq, 0);
      end
    end

    // R7 stall on a full queue
    send_word(32'h0000_0006);
    send_word(TG3);
    for (int k = 0; k < 4; k++) send_word(word_of(7, 6, k));
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = word_of(7, 6, 4);
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b0, "R7 ready low on full", in_ready, 0);
    chk(cnt(3) == QD, "R7 count at full", cnt(3), QD);
    fork
      begin
        send_word(word_of(7, 6, 4));
        send_word(word_of(7, 6, 5));
      end
      begin
        for (int k = 0; k < 6; k++) pop_check(3, word_of(7, 6, k), "R7 no loss order");
      end
    join
    @(negedge clk);
    chk(q_count == '0, "R7 drained", q_count, 0);
    chk(in_ready == 1'b1, "R7 ready back", in_ready, 1);

    // next message after the stall lands normally
    send_word(32'h0000_0001);
    send_word(MISS);
    send_word(32'hCAFE_0001);
    @(negedge clk);
    chk(catch_irq == 1'b1, "R6 irq set", catch_irq, 1);
    pop_check(4, 32'hCAFE_0001, "R5 catch-all data");
    @(negedge clk);
    chk(catch_irq == 1'b0, "R6 irq drop", catch_irq, 0);

    finish_run();
  end
endmodule